// File: doc/BRIEF.md
# Two-Wire Program/Verify Command Interface

This block is the target-side front end of a two-wire serial programming port. An external host drives a slow serial clock pin and a bidirectional data pin. The block samples both pins with the much faster system clock. It collects six-bit commands and decodes them into one-cycle strobes for the memory controller. Two of the commands carry a sixteen-clock data frame. For a load command the block gathers a word from the host. For a read command it drives a word back out onto the data pin, using an output-enable for tristate control.

The host enters the mode through a single enable input. While that input is low the whole interface is held cleared and the data pin stays released. The memory controller receives the command strobes and a 12-bit load word. During a read it returns a 12-bit read word, which must be stable by the second data clock of the frame.

Top module: `pv_serial_if`

## Requirements
- R1: A command is six serial-clock cycles long. Each bit is captured on a falling edge of the serial clock, least significant bit first, and the command takes effect after the sixth falling edge.
- R2: Bits [3:0] of the command select the operation and bits [5:4] are ignored. The codes are: 0x2 load, 0x4 read, 0x6 address increment, 0x8 program start, 0xE program stop and 0x9 bulk erase. Each decoded command raises exactly one strobe for one system-clock cycle, and at most one strobe is high at any time.
- R3: A command whose low four bits match none of the six codes raises no strobe, and it is not followed by a data frame. The next six serial clocks form a new command.
- R4: A load command is followed by a sixteen-clock frame. The data pin is ignored on the falling edges of clocks 1 and 16. Clocks 2 to 15 carry 14 bits, least significant bit first. After the sixteenth falling edge, the low 12 of those bits appear on `load_word_o` while `cmd_load_o` pulses, and the top two bits are dropped.
- R5: A read command pulses `cmd_read_o` when it is decoded. In the following sixteen-clock frame, `sdat_oe_o` rises on the rising edge of data clock 2 and falls on the rising edge of data clock 16. It is low on data clock 1.
- R6: During a read frame, data clocks 2 to 15 carry `rd_word_i` least significant bit first, followed by two bits that are always 1. These 14 bits form the word {2'b11, rd_word_i}.
- R7: While `mode_en_i` is low, all state is cleared, `sdat_oe_o` is low and no strobe is raised. A frame that was cut short does not resume, and the next serial clocks form a new command.
- R8: Both pins pass through a two-flop synchronizer before edge detection. While the pin is driven, `sdat_o` changes only in the system cycle that follows a detected rising edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_en_i | input | 1 | Program/verify mode enable; low clears the interface |
| sclk_i | input | 1 | Serial clock pin from the host (asynchronous) |
| sdat_i | input | 1 | Serial data pin, input side (asynchronous) |
| sdat_o | output | 1 | Serial data pin, output value |
| sdat_oe_o | output | 1 | Serial data pin output enable |
| cmd_load_o | output | 1 | Load word ready strobe |
| cmd_read_o | output | 1 | Read request strobe |
| cmd_incr_o | output | 1 | Address increment strobe |
| cmd_bprog_o | output | 1 | Program start strobe |
| cmd_eprog_o | output | 1 | Program stop strobe |
| cmd_erase_o | output | 1 | Bulk erase strobe |
| load_word_o | output | 12 | Word received by the last load frame |
| rd_word_i | input | 12 | Word to send during a read frame |

## Verification
The bench plays the host at the pin level. It sends every valid code with random values in the ignored top bits, and unknown codes next to valid ones, to show that decoding depends only on the low nibble and that an unknown code consumes no frame. Load frames use random words, random start and stop bits and random values in the dropped top bits, which separates bit order, the stop-bit boundary and truncation. Read frames use random words and sample the enable on every data clock, which exposes off-by-one turnaround errors. Dropping the mode enable in the middle of a load frame and of a read frame shows that the pin is released and that a cut-short frame does not resume.

// File: rtl/pv_pkg.sv
package pv_pkg;
  localparam int CMD_W     = 6;
  localparam int CODE_W    = 4;
  localparam int DATA_BITS = 14;
  localparam int WORD_W    = 12;
  localparam int FRAME_LEN = 16;

  typedef enum logic [CODE_W-1:0] {
    OP_LOAD  = 4'h2,
    OP_READ  = 4'h4,
    OP_INCR  = 4'h6,
    OP_BPROG = 4'h8,
    OP_ERASE = 4'h9,
    OP_EPROG = 4'hE
  } op_e;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_LOAD = 2'd1,
    FR_READ = 2'd2
  } frame_st_e;
endpackage

// File: rtl/pv_pin_sync.sv
module pv_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pv_cmd_rx.sv
module pv_cmd_rx #(
  parameter int CMD_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             fall_i,
  input  logic             din_i,
  output logic             done_o,
  output logic [CMD_W-1:0] code_o
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (clr_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (en_i && fall_i) begin
      sr_d = {din_i, sr_q[CMD_W-1:1]};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign code_o = sr_q;
endmodule

// File: rtl/pv_frame.sv
module pv_frame
  import pv_pkg::*;
#(
  parameter int DATA_BITS = 14,
  parameter int WORD_W    = 12,
  parameter int FRAME_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_load_i,
  input  logic              start_read_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              busy_o,
  output logic              load_done_o,
  output logic [WORD_W-1:0] load_word_o,
  output logic              dout_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int PAD_W = DATA_BITS - WORD_W;
  localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(2);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] STOP_CLK  = CNT_W'(FRAME_LEN);

  frame_st_e            st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d, cnt_inc;
  logic [DATA_BITS-1:0] rx_q, rx_d, tx_q, tx_d, tx_full;
  logic [WORD_W-1:0]    word_q, word_d;
  logic                 done_q, done_d, dout_q, dout_d, oe_q, oe_d;

  assign cnt_inc = cnt_q + 1'b1;
  assign tx_full = {{PAD_W{1'b1}}, rd_word_i};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    word_d = word_q;
    done_d = 1'b0;
    dout_d = dout_q;
    oe_d   = oe_q;
    if (clr_i) begin
      st_d   = FR_IDLE;
      cnt_d  = '0;
      rx_d   = '0;
      tx_d   = '0;
      dout_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        FR_IDLE: begin
          cnt_d = '0;
          if (start_load_i)      st_d = FR_LOAD;
          else if (start_read_i) st_d = FR_READ;
        end
        FR_LOAD: begin
          if (fall_i) begin
            cnt_d = cnt_inc;
            if (cnt_inc >= FIRST_BIT && cnt_inc <= LAST_BIT)
              rx_d = {din_i, rx_q[DATA_BITS-1:1]};
            if (cnt_inc == STOP_CLK) begin
              word_d = rx_q[WORD_W-1:0];
              done_d = 1'b1;
              cnt_d  = '0;
              st_d   = FR_IDLE;
            end
          end
        end
        FR_READ: begin
          if (rise_i) begin
            cnt_d = cnt_inc;
            if (cnt_inc == FIRST_BIT) begin
              dout_d = tx_full[0];
              tx_d   = {1'b1, tx_full[DATA_BITS-1:1]};
              oe_d   = 1'b1;
            end else if (cnt_inc > FIRST_BIT && cnt_inc <= LAST_BIT) begin
              dout_d = tx_q[0];
              tx_d   = {1'b1, tx_q[DATA_BITS-1:1]};
            end else if (cnt_inc == STOP_CLK) begin
              oe_d   = 1'b0;
              dout_d = 1'b0;
            end
          end else if (fall_i && cnt_q == STOP_CLK) begin
            cnt_d = '0;
            st_d  = FR_IDLE;
          end
        end
        default: st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      word_q <= word_d;
      done_q <= done_d;
      dout_q <= dout_d;
      oe_q   <= oe_d;
    end
  end

  assign busy_o      = (st_q != FR_IDLE);
  assign load_done_o = done_q;
  assign load_word_o = word_q;
  assign dout_o      = dout_q;
  assign oe_o        = oe_q;
endmodule

// File: rtl/pv_serial_if.sv
module pv_serial_if
  import pv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_en_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe_o,
  output logic              cmd_load_o,
  output logic              cmd_read_o,
  output logic              cmd_incr_o,
  output logic              cmd_bprog_o,
  output logic              cmd_eprog_o,
  output logic              cmd_erase_o,
  output logic [WORD_W-1:0] load_word_o,
  input  logic [WORD_W-1:0] rd_word_i
);
  logic [1:0]       pins_s;
  logic             sclk_s, sdat_s, sclk_prev_q;
  logic             sclk_rise, sclk_fall, clr;
  logic             cmd_done, frame_busy, start_load, start_read;
  logic [CMD_W-1:0] cmd_code;
  logic [3:0]       stb_q, stb_d;

  assign clr = !mode_en_i;

  pv_pin_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({sdat_i, sclk_i}),
    .sync_o (pins_s)
  );
  assign sclk_s = pins_s[0];
  assign sdat_s = pins_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= clr ? 1'b0 : sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_prev_q && mode_en_i;
  assign sclk_fall = !sclk_s && sclk_prev_q && mode_en_i;

  pv_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (!frame_busy),
    .fall_i (sclk_fall),
    .din_i  (sdat_s),
    .done_o (cmd_done),
    .code_o (cmd_code)
  );

  // decode of the low nibble; upper command bits are don't-care
  always_comb begin
    start_load = 1'b0;
    start_read = 1'b0;
    stb_d      = '0; // {erase, eprog, bprog, incr}
    if (cmd_done && mode_en_i) begin
      case (cmd_code[CODE_W-1:0])
        OP_LOAD:  start_load = 1'b1;
        OP_READ:  start_read = 1'b1;
        OP_INCR:  stb_d[0]   = 1'b1;
        OP_BPROG: stb_d[1]   = 1'b1;
        OP_EPROG: stb_d[2]   = 1'b1;
        OP_ERASE: stb_d[3]   = 1'b1;
        default:  ;
      endcase
    end
  end

  logic read_stb_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q      <= '0;
      read_stb_q <= 1'b0;
    end else begin
      stb_q      <= stb_d;
      read_stb_q <= start_read;
    end
  end

  pv_frame #(
    .DATA_BITS (DATA_BITS),
    .WORD_W    (WORD_W),
    .FRAME_LEN (FRAME_LEN)
  ) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .start_load_i (start_load),
    .start_read_i (start_read),
    .rise_i       (sclk_rise),
    .fall_i       (sclk_fall),
    .din_i        (sdat_s),
    .rd_word_i    (rd_word_i),
    .busy_o       (frame_busy),
    .load_done_o  (cmd_load_o),
    .load_word_o  (load_word_o),
    .dout_o       (sdat_o),
    .oe_o         (sdat_oe_o)
  );

  assign cmd_read_o  = read_stb_q;
  assign cmd_incr_o  = stb_q[0];
  assign cmd_bprog_o = stb_q[1];
  assign cmd_eprog_o = stb_q[2];
  assign cmd_erase_o = stb_q[3];
endmodule

// File: rtl/pv_serial_if_chk.sv
module pv_serial_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_en_i,
  input logic       sclk_rise,
  input logic       sdat_o,
  input logic       sdat_oe_o,
  input logic [5:0] strobes
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobes)); // R2

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> (!sdat_oe_o && strobes == 6'b0)); // R7

  AST_OE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdat_oe_o) |-> $past(sclk_rise)); // R5

  AST_OE_DROP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sdat_oe_o) && $past(mode_en_i)) |-> $past(sclk_rise)); // R5

  AST_DOUT_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdat_oe_o && $past(sdat_oe_o) && !$past(sclk_rise)) |-> $stable(sdat_o)); // R8

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobes != 6'b0) |=> (strobes == 6'b0)); // R2
endmodule

bind pv_serial_if pv_serial_if_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_en_i (mode_en_i),
  .sclk_rise (sclk_rise),
  .sdat_o    (sdat_o),
  .sdat_oe_o (sdat_oe_o),
  .strobes   ({cmd_load_o, cmd_read_o, cmd_incr_o, cmd_bprog_o, cmd_eprog_o, cmd_erase_o})
);

// File: tb/pv_serial_if_tb.sv
`timescale 1ns/100ps
module pv_serial_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0;
  logic        sclk = 1'b0;
  logic        host_dat = 1'b0;
  logic        sdat_o, sdat_oe;
  logic        c_load, c_read, c_incr, c_bprog, c_eprog, c_erase;
  logic [11:0] load_word, rd_word = 12'h0;
  logic        pin;

  int total = 0;
  int bad = 0;
  int n_load = 0, n_read = 0, n_incr = 0, n_bprog = 0, n_eprog = 0, n_erase = 0;
  int e_load = 0, e_read = 0, e_incr = 0, e_bprog = 0, e_eprog = 0, e_erase = 0;
  logic [11:0] last_load = 12'h0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pin = sdat_oe ? sdat_o : host_dat;

  pv_serial_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(mode_en), .sclk_i(sclk), .sdat_i(pin),
    .sdat_o(sdat_o), .sdat_oe_o(sdat_oe), .cmd_load_o(c_load), .cmd_read_o(c_read),
    .cmd_incr_o(c_incr), .cmd_bprog_o(c_bprog), .cmd_eprog_o(c_eprog),
    .cmd_erase_o(c_erase), .load_word_o(load_word), .rd_word_i(rd_word)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (c_load) begin n_load++; last_load = load_word; end
      if (c_read)  n_read++;
      if (c_incr)  n_incr++;
      if (c_bprog) n_bprog++;
      if (c_eprog) n_eprog++;
      if (c_erase) n_erase++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_cnt(int a, int b, int c, int d, int e, int f);
    return {2'b0, a[4:0], b[4:0], c[4:0], d[4:0], e[4:0], f[4:0]};
  endfunction

  task automatic check_counts(string req);
    check(req, pack_cnt(n_load, n_read, n_incr, n_bprog, n_eprog, n_erase),
               pack_cnt(e_load, e_read, e_incr, e_bprog, e_eprog, e_erase));
  endtask

  task automatic wait_sys(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_bit(logic b);
    host_dat = b;
    wait_sys(8);
    sclk = 1'b1;
    wait_sys(8);
    sclk = 1'b0;
    wait_sys(8);
  endtask

  task automatic send_cmd(logic [5:0] c);
    for (int i = 0; i < 6; i++) host_bit(c[i]);
    wait_sys(6);
  endtask

  task automatic load_frame(logic [13:0] d);
    host_bit(1'($urandom));
    for (int i = 0; i < 14; i++) host_bit(d[i]);
    host_bit(1'($urandom));
    wait_sys(6);
  endtask

  task automatic read_frame(output logic [13:0] bits, output logic [15:0] oe_pat);
    bits = '0;
    oe_pat = '0;
    for (int i = 1; i <= 16; i++) begin
      host_dat = 1'($urandom);
      wait_sys(8);
      sclk = 1'b1;
      wait_sys(8);
      oe_pat[i-1] = sdat_oe;
      if (i >= 2 && i <= 15) bits[i-2] = sdat_o;
      sclk = 1'b0;
      wait_sys(8);
    end
    wait_sys(6);
  endtask

  function automatic logic [5:0] with_top(logic [3:0] code);
    return {2'($urandom), code};
  endfunction

  task automatic do_load(logic [11:0] w);
    logic [13:0] d;
    d = {2'($urandom), w};
    send_cmd(with_top(4'h2));
    load_frame(d);
    e_load++;
    check("R4 load word", {20'b0, last_load}, {20'b0, w});
    check_counts("R4 strobe counts after load");
  endtask

  task automatic do_read(logic [11:0] w);
    logic [13:0] bits;
    logic [15:0] oe_pat;
    rd_word = w;
    send_cmd(with_top(4'h4));
    e_read++;
    check_counts("R5 read strobe");
    read_frame(bits, oe_pat);
    check("R5 oe pattern", {16'b0, oe_pat}, {16'b0, 16'h7FFE});
    check("R6 read bits", {18'b0, bits}, {18'b0, 2'b11, w});
  endtask

  initial begin
    wait_sys(150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] bits;
    logic [15:0] oe_pat;
    void'($urandom(32'd2718));
    wait_sys(4);
    check("R7 reset oe", {31'b0, sdat_oe}, 32'd0);
    rst_n = 1'b1;
    wait_sys(4);
    check("R7 mode off oe", {31'b0, sdat_oe}, 32'd0);
    check_counts("R7 no strobes at reset");
    mode_en = 1'b1;
    wait_sys(10);

    // R1 R2: every operation, random don't-care top bits
    send_cmd(with_top(4'h6)); e_incr++;  check_counts("R2 incr");
    send_cmd(with_top(4'h8)); e_bprog++; check_counts("R2 begin program");
    send_cmd(with_top(4'hE)); e_eprog++; check_counts("R2 end program");
    send_cmd(with_top(4'h9)); e_erase++; check_counts("R2 erase");
    send_cmd(6'b110110);      e_incr++;  check_counts("R1 R2 incr with top bits set");

    // R4 directed corners
    do_load(12'h000);
    do_load(12'hFFF);
    do_load(12'hA5C);

    // R3: unknown codes consume no frame
    send_cmd(6'h3F);
    check_counts("R3 unknown 0xF ignored");
    send_cmd(6'h05);
    send_cmd(with_top(4'h6)); e_incr++;
    check_counts("R3 command after unknown decoded");
    send_cmd(6'h00);
    do_load(12'h3C3);

    // R5 R6 directed
    do_read(12'h000);
    do_read(12'hFFF);
    do_read(12'h5A1);

    // random mix
    for (int k = 0; k < 24; k++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      if (sel == 0)      do_load(12'($urandom));
      else if (sel == 1) do_read(12'($urandom));
      else if (sel == 2) begin send_cmd(with_top(4'h6)); e_incr++; check_counts("R2 random incr"); end
      else begin send_cmd({2'($urandom), 4'hB}); check_counts("R3 random unknown"); end
    end

    // R7: cut a load frame short
    send_cmd(with_top(4'h2));
    for (int i = 0; i < 5; i++) host_bit(1'b1);
    mode_en = 1'b0;
    wait_sys(12);
    mode_en = 1'b1;
    wait_sys(10);
    send_cmd(with_top(4'h6)); e_incr++;
    check_counts("R7 aborted load gives no load strobe, next command decoded");

    // R7: cut a read frame short while pin is driven
    rd_word = 12'h123;
    send_cmd(with_top(4'h4)); e_read++;
    for (int i = 0; i < 4; i++) host_bit(1'b0);
    check("R5 pin driven mid read", {31'b0, sdat_oe}, 32'd1);
    mode_en = 1'b0;
    wait_sys(3);
    check("R7 pin released on mode off", {31'b0, sdat_oe}, 32'd0);
    wait_sys(10);
    mode_en = 1'b1;
    wait_sys(10);
    do_read(12'hC0F);
    check_counts("R7 final counts");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule